// File: doc/BRIEF.md
# Fracturable Six-Input Logic Slice

This block is a logic slice of four lookup elements with six inputs each. Every lookup element holds a 64-bit truth table, and every element comes with a pair of flip-flops. Each element gives two combinational results. The full result reads the table at the six-bit input. The half result reads the lower 32 entries at the five lower inputs. When the top input is held high, the full result reads only the upper 32 entries. The element then carries two independent five-input functions on one shared set of inputs.

Two first-level wide multiplexers each join the full results of one pair of elements. A second-level multiplexer joins the two first-level outputs, so one slice can form any function of up to eight inputs. Every element also has a bypass bit. The bypass bit can select a wide multiplexer, and it can be loaded straight into a flip-flop without passing through the table.

All eight flip-flops share one clock, one clock enable and one synchronous, active-high set/reset. A configuration bit decides whether set/reset forces the flip-flops to 1 or to 0. The source of each flip-flop is chosen by a static two-bit code, decoded into the named source states listed below.

- The primary flip-flop of a pair takes the full result on code 00 (SRC_O6) or the half result on code 01 (SRC_O5). On codes 10 (SRC_BYP) and 11 (SRC_RSV) it takes the bypass bit.
- The secondary flip-flop takes the half result on code 01. On every other code it takes the bypass bit, because the full result has no path to it.

Top module: `frac_lut_slice`

## Requirements
- R1: For each element i, `o6[i]` equals bit n of the table `cfg_init[64*i +: 64]`, where n is the six-bit value `lut_in[6*i +: 6]` and bit 0 of that value is its least significant bit.
- R2: `o5[i]` equals bit m of the same table, where m is the five lower input bits. With input bit 5 high, `o6[i]` reads table bits 32 to 63 while `o5[i]` reads bits 0 to 31, so the two outputs give independent five-input functions. With input bit 5 low, the two outputs are equal.
- R3: `f7_out[0]` is `o6[1]` when `byp[0]` is 1 and `o6[0]` otherwise. `f7_out[1]` is `o6[3]` when `byp[2]` is 1 and `o6[2]` otherwise.
- R4: `f8_out` is `f7_out[1]` when `byp[1]` is 1 and `f7_out[0]` otherwise.
- R5: When `ce` is high and `sr` is low, the primary flip-flop `q_a[i]` loads at the clock edge according to `cfg_dsel_a[2*i +: 2]`. Code 00 loads `o6[i]`, code 01 loads `o5[i]`, and codes 10 and 11 load `byp[i]`.
- R6: When `ce` is high and `sr` is low, the secondary flip-flop `q_b[i]` loads `o5[i]` when `cfg_dsel_b[2*i +: 2]` is 01. On codes 00, 10 and 11 it loads `byp[i]`, so code 00 does not give it `o6[i]`.
- R7: When `sr` is high at a clock edge, all eight flip-flops load `cfg_sr_set`, whatever the value of `ce`.
- R8: When `sr` and `ce` are both low at a clock edge, all eight flip-flops keep their values.
- R9: Loading a bypass bit into a flip-flop leaves the combinational outputs `o6` and `o5` unchanged; they still give the table functions of the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all flip-flops |
| ce | input | 1 | Clock enable shared by all flip-flops |
| sr | input | 1 | Synchronous set/reset, active high |
| cfg_sr_set | input | 1 | Value forced by set/reset (1 sets, 0 clears) |
| cfg_init | input | 256 | Four 64-bit truth tables, element i at bits 64*i+63 down to 64*i |
| cfg_dsel_a | input | 8 | Primary flip-flop source code, two bits per element |
| cfg_dsel_b | input | 8 | Secondary flip-flop source code, two bits per element |
| lut_in | input | 24 | Six table inputs per element, element i at bits 6*i+5 down to 6*i |
| byp | input | 4 | Bypass bit per element (flip-flop data or wide-mux select) |
| o6 | output | 4 | Full six-input result per element |
| o5 | output | 4 | Half five-input result per element |
| f7_out | output | 2 | First-level wide multiplexer outputs |
| f8_out | output | 1 | Second-level wide multiplexer output |
| q_a | output | 4 | Primary flip-flop of each pair |
| q_b | output | 4 | Secondary flip-flop of each pair |

## Verification
Two pairs of functions can act in the same cycle. The first pair is set/reset and a clock-enabled load. The bench drives `sr` and `ce` high together on the same edge, with bypass data that is the inverse of `cfg_sr_set`. The flip-flops must show the forced value and not the bypass data.

The second pair is the bypass bit, which can steer a wide multiplexer and feed a flip-flop on the same edge. The bench sweeps the register source codes with bypass patterns that also toggle the multiplexer selects. It then judges `f7_out`, `f8_out`, `o6` and the captured flip-flop values separately, each against its own arithmetic expectation.

// File: rtl/fls_pkg.sv
package fls_pkg;

    // Static source code of a flip-flop's data input.
    typedef enum logic [1:0] {
        SRC_O6  = 2'b00,
        SRC_O5  = 2'b01,
        SRC_BYP = 2'b10,
        SRC_RSV = 2'b11
    } dsrc_e;

endpackage

// File: rtl/lut6_frac.sv
module lut6_frac #(
    parameter int K = 6
) (
    input  logic [2**K-1:0] init,
    input  logic [K-1:0]    sel,
    output logic            o6,
    output logic            o5
);
    localparam int HALF_W = 2**(K-1);

    logic [HALF_W-1:0] low_half;

    assign low_half = init[HALF_W-1:0];
    assign o6       = init[sel];
    assign o5       = low_half[sel[K-2:0]];

    // With the top input low, both outputs read the same lower-half entry.
    always_comb begin
        if (!sel[K-1]) begin
            AST_HALVES_AGREE: assert (o5 == o6); // R2
        end
    end

endmodule

// File: rtl/fls_reg_pair.sv
module fls_reg_pair
    import fls_pkg::*;
(
    input  logic       clk,
    input  logic       ce,
    input  logic       sr,
    input  logic       sr_val,
    input  logic       o6,
    input  logic       o5,
    input  logic       byp,
    input  logic [1:0] dsel_a,
    input  logic [1:0] dsel_b,
    output logic       q_a,
    output logic       q_b
);
    dsrc_e src_a;
    dsrc_e src_b;
    logic  d_a;
    logic  d_b;

    assign src_a = dsrc_e'(dsel_a);
    assign src_b = dsrc_e'(dsel_b);

    // Output-side decode: the primary flip-flop reaches both LUT results.
    always_comb begin
        unique case (src_a)
            SRC_O6:  d_a = o6;
            SRC_O5:  d_a = o5;
            SRC_BYP: d_a = byp;
            default: d_a = byp;
        endcase
    end

    // The secondary flip-flop has no path from the full result.
    always_comb begin
        unique case (src_b)
            SRC_O5:  d_b = o5;
            default: d_b = byp;
        endcase
    end

    // State register: set/reset outranks the clock enable.
    always_ff @(posedge clk) begin
        if (sr) begin
            q_a <= sr_val;
            q_b <= sr_val;
        end else if (ce) begin
            q_a <= d_a;
            q_b <= d_b;
        end
    end

    // Set/reset is the trigger here, so it cannot also disable the check.
    AST_SR_FORCE: assert property (@(posedge clk)
        sr |=> (q_a == $past(sr_val)) && (q_b == $past(sr_val))); // R7

    AST_CE_HOLD: assert property (@(posedge clk) disable iff (sr)
        !ce |=> $stable(q_a) && $stable(q_b)); // R8

    AST_A_BYPASS: assert property (@(posedge clk) disable iff (sr)
        (ce && dsel_a[1]) |=> (q_a == $past(byp))); // R5

    AST_B_NO_FULL: assert property (@(posedge clk) disable iff (sr)
        (ce && dsel_b != 2'b01) |=> (q_b == $past(byp))); // R6

endmodule

// File: rtl/fls_wide_mux.sv
module fls_wide_mux #(
    parameter int NUM_LUTS = 4
) (
    input  logic [NUM_LUTS-1:0]   o6,
    input  logic [NUM_LUTS-1:0]   byp,
    output logic [NUM_LUTS/2-1:0] f7,
    output logic                  f8
);
    localparam int NUM_F7 = NUM_LUTS / 2;

    for (genvar p = 0; p < NUM_F7; p++) begin : g_f7
        assign f7[p] = byp[2*p] ? o6[2*p+1] : o6[2*p];
    end

    assign f8 = byp[1] ? f7[1] : f7[0];

    // The second-level result always comes from one of the full results.
    always_comb begin
        if (o6 == '0) begin
            AST_F8_FROM_LUTS: assert (!f8); // R4
        end
    end

endmodule

// File: rtl/frac_lut_slice.sv
module frac_lut_slice #(
    parameter int NUM_LUTS = 4,
    parameter int LUT_K    = 6
) (
    input  logic                          clk,
    input  logic                          ce,
    input  logic                          sr,
    input  logic                          cfg_sr_set,
    input  logic [NUM_LUTS*(2**LUT_K)-1:0] cfg_init,
    input  logic [NUM_LUTS*2-1:0]         cfg_dsel_a,
    input  logic [NUM_LUTS*2-1:0]         cfg_dsel_b,
    input  logic [NUM_LUTS*LUT_K-1:0]     lut_in,
    input  logic [NUM_LUTS-1:0]           byp,
    output logic [NUM_LUTS-1:0]           o6,
    output logic [NUM_LUTS-1:0]           o5,
    output logic [NUM_LUTS/2-1:0]         f7_out,
    output logic                          f8_out,
    output logic [NUM_LUTS-1:0]           q_a,
    output logic [NUM_LUTS-1:0]           q_b
);
    localparam int INIT_W = 2**LUT_K;

    for (genvar i = 0; i < NUM_LUTS; i++) begin : g_elem
        lut6_frac #(.K(LUT_K)) u_lut (
            .init (cfg_init[i*INIT_W +: INIT_W]),
            .sel  (lut_in[i*LUT_K +: LUT_K]),
            .o6   (o6[i]),
            .o5   (o5[i])
        );

        fls_reg_pair u_regs (
            .clk    (clk),
            .ce     (ce),
            .sr     (sr),
            .sr_val (cfg_sr_set),
            .o6     (o6[i]),
            .o5     (o5[i]),
            .byp    (byp[i]),
            .dsel_a (cfg_dsel_a[2*i +: 2]),
            .dsel_b (cfg_dsel_b[2*i +: 2]),
            .q_a    (q_a[i]),
            .q_b    (q_b[i])
        );
    end

    fls_wide_mux #(.NUM_LUTS(NUM_LUTS)) u_wide (
        .o6  (o6),
        .byp (byp),
        .f7  (f7_out),
        .f8  (f8_out)
    );

endmodule

// File: tb/frac_lut_slice_bench.sv
module frac_lut_slice_bench;
    logic         clk = 1'b0;
    logic         ce = 1'b0;
    logic         sr = 1'b1;
    logic         cfg_sr_set = 1'b0;
    logic [255:0] cfg_init = '0;
    logic [7:0]   cfg_dsel_a = '0;
    logic [7:0]   cfg_dsel_b = '0;
    logic [23:0]  lut_in = '0;
    logic [3:0]   byp = '0;
    logic [3:0]   o6, o5, q_a, q_b;
    logic [1:0]   f7_out;
    logic         f8_out;

    int n_run = 0;
    int n_fail = 0;

    frac_lut_slice u_frac_lut_slice (
        .clk(clk), .ce(ce), .sr(sr), .cfg_sr_set(cfg_sr_set),
        .cfg_init(cfg_init), .cfg_dsel_a(cfg_dsel_a), .cfg_dsel_b(cfg_dsel_b),
        .lut_in(lut_in), .byp(byp), .o6(o6), .o5(o5),
        .f7_out(f7_out), .f8_out(f8_out), .q_a(q_a), .q_b(q_b)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [63:0] table_for(input int i);
        return (64'h9E3779B97F4A7C15 * 64'(i + 3)) ^ (64'hC2B2AE3D27D4EB4F >> i);
    endfunction

    function automatic logic [5:0] in_of(input int i);
        return lut_in[6*i +: 6];
    endfunction

    function automatic logic exp6(input int i);
        return ((cfg_init[64*i +: 64] >> in_of(i)) & 64'd1) != 0;
    endfunction

    function automatic logic exp5(input int i);
        return ((cfg_init[64*i +: 64] >> (in_of(i) % 32)) & 64'd1) != 0;
    endfunction

    function automatic logic [3:0] exp6_all();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = exp6(i);
        return v;
    endfunction

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] e6, e5, ea, eb, prev_a, prev_b;
        for (int i = 0; i < 4; i++) cfg_init[64*i +: 64] = table_for(i);

        // Reset state: clear on set/reset
        tick();
        tick();
        chk("R7 reset q_a", 32'(q_a), 32'h0);
        chk("R7 reset q_b", 32'(q_b), 32'h0);
        sr = 1'b0;

        // Full and half results over every input value
        for (int v = 0; v < 64; v++) begin
            for (int i = 0; i < 4; i++) lut_in[6*i +: 6] = 6'((v + 17*i) % 64);
            #1;
            for (int i = 0; i < 4; i++) begin
                chk("R1 o6", 32'(o6[i]), 32'(exp6(i)));
                chk("R2 o5", 32'(o5[i]), 32'(exp5(i)));
                if (in_of(i)[5] == 1'b0) chk("R2 o5 equals o6 low half", 32'(o5[i]), 32'(o6[i]));
            end
        end

        // Dual mode: lower half = in0 AND in1, upper half = in2 XOR in3 XOR in4
        for (int k = 0; k < 64; k++) begin
            logic [4:0] lo;
            lo = 5'(k % 32);
            cfg_init[k] = (k < 32) ? (lo[0] & lo[1]) : (lo[2] ^ lo[3] ^ lo[4]);
        end
        for (int v = 0; v < 32; v++) begin
            logic [4:0] w;
            w = 5'(v);
            lut_in[5:0] = {1'b1, w};
            #1;
            chk("R2 dual o5 two-input AND", 32'(o5[0]), 32'(w[0] & w[1]));
            chk("R2 dual o6 three-input XOR", 32'(o6[0]), 32'(w[2] ^ w[3] ^ w[4]));
        end

        // Wide multiplexers over all bypass selects and several input patterns
        for (int pat = 0; pat < 6; pat++) begin
            for (int i = 0; i < 4; i++) lut_in[6*i +: 6] = 6'((pat * 11 + i * 23) % 64);
            for (int b = 0; b < 16; b++) begin
                logic [1:0] e7;
                logic       e8;
                byp = 4'(b);
                #1;
                e6 = exp6_all();
                e7[0] = byp[0] ? e6[1] : e6[0];
                e7[1] = byp[2] ? e6[3] : e6[2];
                e8 = byp[1] ? e7[1] : e7[0];
                chk("R3 f7", 32'(f7_out), 32'(e7));
                chk("R4 f8", 32'(f8_out), 32'(e8));
            end
        end

        // Flip-flop source steering over every code pair
        ce = 1'b1;
        for (int da = 0; da < 4; da++) begin
            for (int db = 0; db < 4; db++) begin
                for (int bp = 0; bp < 2; bp++) begin
                    cfg_dsel_a = {4{2'(da)}};
                    cfg_dsel_b = {4{2'(db)}};
                    for (int i = 0; i < 4; i++)
                        lut_in[6*i +: 6] = 6'((da * 13 + db * 7 + bp * 29 + i * 37) % 64);
                    byp = bp ? 4'b1010 : 4'b0101;
                    #1;
                    for (int i = 0; i < 4; i++) begin
                        e5[i] = exp5(i);
                        e6[i] = exp6(i);
                        ea[i] = (da == 0) ? e6[i] : (da == 1) ? e5[i] : byp[i];
                        eb[i] = (db == 1) ? e5[i] : byp[i];
                    end
                    tick();
                    chk("R5 q_a source", 32'(q_a), 32'(ea));
                    chk("R6 q_b source", 32'(q_b), 32'(eb));
                    chk("R9 o6 undisturbed by load", 32'(o6), 32'(e6));
                end
            end
        end

        // Clock enable low holds, while data inputs change
        prev_a = q_a;
        prev_b = q_b;
        ce = 1'b0;
        cfg_dsel_a = '1;
        cfg_dsel_b = '1;
        byp = ~q_a;
        tick();
        chk("R8 hold q_a", 32'(q_a), 32'(prev_a));
        chk("R8 hold q_b", 32'(q_b), 32'(prev_b));

        // Set/reset and enabled load on the same edge: set/reset wins
        ce = 1'b1;
        sr = 1'b1;
        cfg_sr_set = 1'b1;
        byp = 4'b0000;
        tick();
        chk("R7 set beats load q_a", 32'(q_a), 32'hF);
        chk("R7 set beats load q_b", 32'(q_b), 32'hF);
        ce = 1'b0;
        cfg_sr_set = 1'b0;
        byp = 4'b1111;
        tick();
        chk("R7 clear without enable q_a", 32'(q_a), 32'h0);
        chk("R7 clear without enable q_b", 32'(q_b), 32'h0);
        sr = 1'b0;
        ce = 1'b1;
        tick();
        chk("R5 bypass load after clear", 32'(q_a), 32'hF);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule